// File: doc/BRIEF.md
# Configurable UART Transmit Engine

This block serialises bytes onto a single transmit line under the control of an 8-bit configuration register. Software writes the register to turn the transmitter and the receiver on or off. The same register chooses one or two stop bits, whether a parity bit is added and which parity sense it uses, whether the line carries a plain NRZ waveform or infrared-style pulses, and which clock source feeds the baud divider. Bytes enter through a single-entry holding buffer. The engine moves each byte into its shifter as soon as the shifter is free and then sends one frame. Each frame is a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Every bit lasts a fixed number of baud ticks.

The register also enforces safe operation. While a frame is on the line, writes to the frame-format fields are dropped. The clock-source field only changes while both enables are off. Turning the transmitter off lets the current frame finish and throws away any waiting byte. A low-power request clears both enables and stops the line at once, and every other setting keeps its value. The baud divider is not part of the block and appears only as a tick input.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, cfg_rdata is 0x00, txd is 1, tx_empty is 1 and tx_busy is 0.
- R2: cfg_rdata shows the register with the transmit enable at bit 7, the receive enable at bit 6, the two-stop-bit select at bit 5, the even-parity select at bit 4, the parity enable at bit 3, the pulse-mode select at bit 2 and the clock-source select at bit 1. Bit 0 always reads 0, and a write lands one cycle after cfg_wr.
- R3: A frame in NRZ mode is a 0 start bit, then 8 data bits least significant first, then stop bits at 1. Each bit lasts 16 baud_tick pulses. Bit 5 = 0 gives one stop bit and bit 5 = 1 gives two.
- R4: With bit 3 = 1, a parity bit follows the data. Bit 4 = 1 makes the count of ones in data plus parity even, and bit 4 = 0 makes it odd. With bit 3 = 0, no parity bit is sent.
- R5: With bit 2 = 1, each 0 bit drives txd high for the first 3 ticks of its 16 and low for the rest. Each 1 bit, and the idle line, hold txd low.
- R6: A dat_wr is accepted only while bit 7 is 1 and tx_empty is 1, and tx_empty falls on the next cycle. A dat_wr while the buffer is full is ignored. tx_empty rises when the byte moves into the shifter.
- R7: tx_busy is 1 from the first cycle of the start bit to the end of the last stop bit. No new frame starts while it is 1.
- R8: Clearing bit 7 during a frame lets that frame run to its end. A byte waiting in the buffer is discarded, tx_empty returns to 1, and no further frame is sent.
- R9: While tx_busy is 1, writes to bits 5, 4, 3, 2 and 1 are ignored. Bits 7 and 6 still take the written value.
- R10: A write to bit 1 takes effect only if bits 7 and 6 both read 0 before the write.
- R11: A lp_req pulse clears bits 7 and 6 on the next cycle and keeps every other bit. A cfg_wr in the same cycle is ignored. Any frame in progress stops at once, so tx_busy falls and txd goes idle, and the buffer empties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration register contents |
| dat_wr | input | 1 | Transmit byte write strobe |
| dat_wdata | input | DATA_W | Transmit byte |
| baud_tick | input | 1 | One-cycle pulse from the external baud divider |
| lp_req | input | 1 | Low-power entry request |
| txd | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Holding buffer is empty |
| tx_busy | output | 1 | A frame is on the line |

## Verification
Several pairs of functions can act in the same cycle. A configuration write can coincide with the first cycle of a frame. A transmitter disable can arrive while a byte waits in the buffer and another is being shifted out. A low-power request can coincide with a register write. The bench causes each of these overlaps by issuing a write or request in the middle of a frame whose buffer it has just refilled. A behavioural model, built from queues and counters, predicts txd, tx_busy, tx_empty and cfg_rdata on every clock. Directed checks confirm which register bits survived and whether the waiting byte was ever sent.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   // Control register image, MSB first as it appears on cfg_rdata.
   typedef struct packed {
      logic txe;      // transmit enable
      logic rxe;      // receive enable
      logic stop2;    // two stop bits
      logic even;     // even parity sense
      logic par_en;   // parity bit present
      logic pulse;    // infrared pulse waveform
      logic clk_sel;  // baud clock source select
      logic rsvd;     // reads zero
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/uart_txc_ctl.sv
module uart_txc_ctl
   import uart_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [CTL_W-1:0] wdata_i,
   input  logic             lp_req_i,
   input  logic             busy_i,
   output ctl_t             ctl_o
);

   ctl_t wr_img;
   logic fmt_open;
   logic src_open;

   assign wr_img   = ctl_t'(wdata_i);
   assign fmt_open = !busy_i;
   assign src_open = !busy_i && !ctl_o.txe && !ctl_o.rxe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_o <= '0;
      end else if (lp_req_i) begin
         ctl_o.txe <= 1'b0;
         ctl_o.rxe <= 1'b0;
      end else if (wr_en_i) begin
         ctl_o.txe <= wr_img.txe;
         ctl_o.rxe <= wr_img.rxe;
         if (fmt_open) begin
            ctl_o.stop2  <= wr_img.stop2;
            ctl_o.even   <= wr_img.even;
            ctl_o.par_en <= wr_img.par_en;
            ctl_o.pulse  <= wr_img.pulse;
         end
         if (src_open) begin
            ctl_o.clk_sel <= wr_img.clk_sel;
         end
      end
   end

   AST_FMT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable({ctl_o.stop2, ctl_o.even, ctl_o.par_en, ctl_o.pulse})); // R9
   AST_SRC_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o.txe || ctl_o.rxe) |=> $stable(ctl_o.clk_sel)); // R10
   AST_LP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      lp_req_i |=> (!ctl_o.txe && !ctl_o.rxe)); // R11
   AST_LP_KEEPS_FMT: assert property (@(posedge clk) disable iff (!rst_n)
      lp_req_i |=> $stable({ctl_o.stop2, ctl_o.even, ctl_o.par_en, ctl_o.pulse, ctl_o.clk_sel})); // R11

endmodule

// File: rtl/uart_txc_buf.sv
module uart_txc_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              txe_i,
   input  logic              flush_i,
   input  logic              take_i,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o
);

   logic accept;

   assign accept = wr_en_i && txe_i && !full_o && !flush_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_o <= 1'b0;
         data_o <= '0;
      end else begin
         if (!txe_i || flush_i || take_i) begin
            full_o <= 1'b0;
         end else if (accept) begin
            full_o <= 1'b1;
         end
         if (accept) begin
            data_o <= wdata_i;
         end
      end
   end

   AST_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !txe_i |=> !full_o); // R8
   AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> full_o); // R6
   AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && txe_i && !take_i && !flush_i) |=> (full_o && $stable(data_o))); // R6

endmodule

// File: rtl/uart_txc_shift.sv
module uart_txc_shift #(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16,
   localparam int FRAME_MAX    = DATA_W + 4,
   localparam int IDXW         = $clog2(FRAME_MAX),
   localparam int TCW          = $clog2(TICKS_PER_BIT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic              ld_par_en_i,
   input  logic              ld_even_i,
   input  logic              ld_stop2_i,
   input  logic              tick_i,
   input  logic              abort_i,
   output logic              busy_o,
   output logic              bit_o,
   output logic [TCW-1:0]    tcnt_o
);

   localparam logic [TCW-1:0]  TC_LAST  = TCW'(TICKS_PER_BIT - 1);
   localparam logic [IDXW-1:0] IDX_BASE = IDXW'(DATA_W + 1);

   logic [FRAME_MAX-1:0] frame;
   logic [IDXW-1:0]      idx;
   logic [IDXW-1:0]      idx_last;
   logic                 par_bit;
   logic                 bit_end;

   assign par_bit = ld_even_i ? (^ld_data_i) : ~(^ld_data_i);
   assign bit_end = busy_o && tick_i && (tcnt_o == TC_LAST);
   assign bit_o   = frame[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o   <= 1'b0;
         frame    <= '1;
         idx      <= '0;
         idx_last <= '0;
         tcnt_o   <= '0;
      end else if (abort_i) begin
         busy_o <= 1'b0;
         idx    <= '0;
         tcnt_o <= '0;
      end else if (load_i) begin
         busy_o   <= 1'b1;
         frame    <= {{(FRAME_MAX - DATA_W - 2){1'b1}},
                      (ld_par_en_i ? par_bit : 1'b1), ld_data_i, 1'b0};
         idx      <= '0;
         tcnt_o   <= '0;
         idx_last <= IDX_BASE + IDXW'(ld_par_en_i) + IDXW'(ld_stop2_i);
      end else if (bit_end) begin
         tcnt_o <= '0;
         if (idx == idx_last) begin
            busy_o <= 1'b0;
            idx    <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end else if (busy_o && tick_i) begin
         tcnt_o <= tcnt_o + 1'b1;
      end
   end

   AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !busy_o); // R7
   AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> !busy_o); // R11
   AST_FRAME_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (idx == '0 && tcnt_o == '0 && !bit_o)); // R3
   AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i && !abort_i) |=> $stable(idx)); // R3

endmodule

// File: rtl/uart_txc_line.sv
module uart_txc_line #(
   parameter int TICKS_PER_BIT = 16,
   parameter int IRDA_PULSE    = 3,
   parameter bit PULSE_EN      = 1'b1,
   localparam int TCW          = $clog2(TICKS_PER_BIT)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           busy_i,
   input  logic           bit_i,
   input  logic [TCW-1:0] tcnt_i,
   input  logic           pulse_sel_i,
   output logic           txd_o
);

   localparam logic [TCW-1:0] PULSE_END = TCW'(IRDA_PULSE);

   logic nrz;

   assign nrz = busy_i ? bit_i : 1'b1;

   generate
      if (PULSE_EN) begin : g_pulse
         logic ir;
         assign ir    = busy_i && !bit_i && (tcnt_i < PULSE_END);
         assign txd_o = pulse_sel_i ? ir : nrz;

         AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            (pulse_sel_i && txd_o) |-> (busy_i && tcnt_i < PULSE_END)); // R5
      end else begin : g_plain
         logic unused_sel;
         assign unused_sel = pulse_sel_i;
         assign txd_o      = nrz;
      end
   endgenerate

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !pulse_sel_i) |-> txd_o); // R3

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
   import uart_tx_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16,
   parameter int IRDA_PULSE    = 3,
   parameter bit PULSE_EN      = 1'b1,
   localparam int TCW          = $clog2(TICKS_PER_BIT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   input  logic              baud_tick,
   input  logic              lp_req,
   output logic              txd,
   output logic              tx_empty,
   output logic              tx_busy
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("DATA_W must lie between 5 and 9");
      end
      if (TICKS_PER_BIT < 4) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be at least 4");
      end
      if (IRDA_PULSE < 1 || IRDA_PULSE >= TICKS_PER_BIT) begin : g_bad_pulse
         $error("IRDA_PULSE must be shorter than a bit");
      end
      if (CTL_W != 8) begin : g_bad_ctl
         $error("control register must be 8 bits");
      end
   endgenerate

   ctl_t              ctl;
   logic              buf_full;
   logic [DATA_W-1:0] buf_data;
   logic              take;
   logic              sh_bit;
   logic [TCW-1:0]    sh_tcnt;

   assign take      = buf_full && ctl.txe && !tx_busy && !lp_req;
   assign cfg_rdata = ctl;
   assign tx_empty  = !buf_full;

   uart_txc_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (cfg_wr),
      .wdata_i  (cfg_wdata),
      .lp_req_i (lp_req),
      .busy_i   (tx_busy),
      .ctl_o    (ctl)
   );

   uart_txc_buf #(.DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (dat_wr),
      .wdata_i (dat_wdata),
      .txe_i   (ctl.txe),
      .flush_i (lp_req),
      .take_i  (take),
      .data_o  (buf_data),
      .full_o  (buf_full)
   );

   uart_txc_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (take),
      .ld_data_i   (buf_data),
      .ld_par_en_i (ctl.par_en),
      .ld_even_i   (ctl.even),
      .ld_stop2_i  (ctl.stop2),
      .tick_i      (baud_tick),
      .abort_i     (lp_req),
      .busy_o      (tx_busy),
      .bit_o       (sh_bit),
      .tcnt_o      (sh_tcnt)
   );

   uart_txc_line #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .IRDA_PULSE    (IRDA_PULSE),
      .PULSE_EN      (PULSE_EN)
   ) u_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (tx_busy),
      .bit_i       (sh_bit),
      .tcnt_i      (sh_tcnt),
      .pulse_sel_i (ctl.pulse),
      .txd_o       (txd)
   );

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(ctl.txe)); // R8
   AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> tx_empty); // R6

endmodule

// File: tb/uart_tx_engine_tb.sv
module uart_tx_engine_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       dat_wr = 1'b0;
   logic [7:0] dat_wdata = 8'h00;
   logic       baud_tick = 1'b0;
   logic       lp_req = 1'b0;
   logic       txd;
   logic       tx_empty;
   logic       tx_busy;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_tx_engine u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .dat_wr    (dat_wr),
      .dat_wdata (dat_wdata),
      .baud_tick (baud_tick),
      .lp_req    (lp_req),
      .txd       (txd),
      .tx_empty  (tx_empty),
      .tx_busy   (tx_busy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Baud tick every other clock.
   always @(negedge clk) begin
      if (!rst_n) baud_tick <= 1'b0;
      else        baud_tick <= ~baud_tick;
   end

   // Behavioural reference model.
   logic [7:0] m_ctl;
   bit         m_full;
   logic [7:0] m_buf;
   bit         m_busy;
   int         m_idx, m_tick, m_last;
   bit         m_bits[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctl = 8'h00; m_full = 0; m_buf = 8'h00; m_busy = 0;
         m_idx = 0; m_tick = 0; m_last = 0; m_bits = {};
      end else begin
         logic [7:0] o_ctl;
         bit o_full, o_busy, take;
         o_ctl = m_ctl; o_full = m_full; o_busy = m_busy;
         take = o_full && o_ctl[7] && !o_busy && !lp_req;
         if (lp_req) begin
            m_busy = 0;
         end else if (take) begin
            m_bits = {};
            m_bits.push_back(1'b0);
            for (int i = 0; i < 8; i++) m_bits.push_back(m_buf[i]);
            if (o_ctl[3]) m_bits.push_back(o_ctl[4] ? ^m_buf : ~^m_buf);
            m_bits.push_back(1'b1);
            if (o_ctl[5]) m_bits.push_back(1'b1);
            m_last = m_bits.size() - 1;
            m_busy = 1; m_idx = 0; m_tick = 0;
         end else if (o_busy && baud_tick) begin
            if (m_tick == 15) begin
               m_tick = 0;
               if (m_idx == m_last) m_busy = 0;
               else m_idx++;
            end else begin
               m_tick++;
            end
         end
         if (!o_ctl[7] || lp_req || take) m_full = 0;
         else if (dat_wr && !o_full) begin m_full = 1; m_buf = dat_wdata; end
         if (lp_req) begin
            m_ctl[7:6] = 2'b00;
         end else if (cfg_wr) begin
            m_ctl[7:6] = cfg_wdata[7:6];
            if (!o_busy) m_ctl[5:2] = cfg_wdata[5:2];
            if (!o_busy && o_ctl[7:6] == 2'b00) m_ctl[1] = cfg_wdata[1];
         end
      end
   end

   function automatic bit exp_txd();
      bit b;
      if (!m_busy) return m_ctl[2] ? 1'b0 : 1'b1;
      b = m_bits[m_idx];
      if (m_ctl[2]) return (b == 1'b0) && (m_tick < 3);
      return b;
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3/R4/R5 txd vs model", int'(txd), int'(exp_txd()));
         chk("R7 tx_busy vs model", int'(tx_busy), int'(m_busy));
         chk("R6 tx_empty vs model", int'(tx_empty), int'(!m_full));
         chk("R2 cfg_rdata vs model", int'(cfg_rdata), int'(m_ctl));
      end
   end

   task automatic cfg(input logic [7:0] w);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); dat_wr = 1'b1; dat_wdata = b;
      @(negedge clk); dat_wr = 1'b0;
   endtask

   task automatic wait_busy();
      for (int i = 0; i < 200 && !tx_busy; i++) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && tx_busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 reset cfg_rdata", int'(cfg_rdata), 8'h00);
      chk("R1 reset txd", int'(txd), 1);
      chk("R1 reset tx_empty", int'(tx_empty), 1);
      chk("R1 reset tx_busy", int'(tx_busy), 0);
      rst_n = 1'b1;

      // R2 / R10: bit 0 reads zero; clock-source write needs both enables off.
      cfg(8'hFF);
      chk("R2 bit0 reads zero", int'(cfg_rdata), 8'hFE);
      cfg(8'h00);
      chk("R10 clock select kept while enabled", int'(cfg_rdata), 8'h02);
      cfg(8'h00);
      chk("R10 clock select cleared when disabled", int'(cfg_rdata), 8'h00);

      // R3 / R4: every stop and parity combination.
      for (int k = 0; k < 8; k++) begin
         logic [7:0] w;
         w = 8'h80 | (k[0] ? 8'h20 : 8'h00) | (k[1] ? 8'h08 : 8'h00) | (k[2] ? 8'h10 : 8'h00);
         cfg(w);
         put(8'h35 + 8'(k * 29));
         wait_busy();
         chk("R7 busy during frame", int'(tx_busy), 1);
         wait_idle();
      end

      // R6: back-to-back bytes and a write while full.
      cfg(8'h80);
      put(8'hA5);
      wait_busy();
      put(8'h3C);
      chk("R6 buffer filled while shifting", int'(tx_empty), 0);
      put(8'hFF);
      chk("R6 write while full ignored", int'(tx_empty), 0);
      wait_idle();
      wait_busy();
      chk("R6 second byte started", int'(tx_busy), 1);
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R6 third byte dropped", int'(tx_busy), 0);

      // R9: format write during a frame ignored, enables still written.
      put(8'h5A);
      wait_busy();
      cfg(8'hFC);
      chk("R9 format locked while busy", int'(cfg_rdata), 8'hC0);
      wait_idle();

      // R8: disable mid-frame with a byte waiting.
      cfg(8'h80);
      put(8'hC3);
      wait_busy();
      repeat (30) @(negedge clk);
      put(8'h81);
      cfg(8'h00);
      @(negedge clk);
      chk("R8 waiting byte discarded", int'(tx_empty), 1);
      chk("R8 frame continues", int'(tx_busy), 1);
      wait_idle();
      repeat (40) @(negedge clk);
      chk("R8 no further frame", int'(tx_busy), 0);

      // R5: pulse mode.
      cfg(8'h84);
      chk("R5 idle line low in pulse mode", int'(txd), 0);
      put(8'h0F);
      wait_busy();
      chk("R5 start bit pulse high", int'(txd), 1);
      wait_idle();

      // R11: low-power request mid-frame with a coincident write.
      cfg(8'hE8);
      put(8'h66);
      wait_busy();
      repeat (40) @(negedge clk);
      put(8'h99);
      @(negedge clk); lp_req = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'hC0;
      @(negedge clk); lp_req = 1'b0; cfg_wr = 1'b0;
      chk("R11 enables cleared, rest kept", int'(cfg_rdata), 8'h28);
      chk("R11 frame stopped", int'(tx_busy), 0);
      chk("R11 line idle", int'(txd), 1);
      chk("R11 buffer emptied", int'(tx_empty), 1);
      cfg(8'h2A);
      chk("R10 clock select written when disabled", int'(cfg_rdata), 8'h2A);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule